// File: doc/BRIEF.md
# Video Frame Validity Gate

The gate sits between the receive side of a serial video link and a downstream video buffer. Each incoming beat carries a data word, a parity-error flag computed upstream, and frame-start, frame-end, line-start and line-end markers. A beat flagged with a parity error can be dropped or passed on. Beats that survive are sent on one clock later.

Alongside the forwarding path, the block measures each frame. It records the length of the first line in data beats and the number of lines, and compares them with the last completed frame. A frame with no parity error and a consistent size extends a run of good frames. When the run reaches a programmed length, a pass status is raised. Any bad frame clears the status again. When pass gating is enabled, whole frames are held back until pass is earned. The gating decision is taken at each frame start.

Dropping beats can leave the downstream side with a frame start that never received its frame end. Each such truncation is flagged on a pulse output that is aligned with the offending start. Three saturating counters report parity hits, gated-off frames and size mismatches. A single pulse clears all three.

Top module: `vid_frame_gate`

## Requirements
- R1: A kept input beat appears on the outputs exactly one clock later, with `outData` and all four markers matching it. A beat that is not kept gives `outValid` = 0 in that cycle.
- R2: With `cfgParChkEn` = 0 the parity flag has no effect at all. The beat is forwarded, `parErrCnt` does not count, and the frame is not made invalid.
- R3: With `cfgParChkEn` = 1, a beat whose parity flag is set is dropped when `cfgFwdParErr` = 0. It is forwarded unchanged when `cfgFwdParErr` = 1. Tying `cfgFwdParErr` low gives the drop behaviour by default.
- R4: `parErrCnt` counts every valid beat whose parity flag is set while `cfgParChkEn` = 1. This applies whether or not the beat is dropped.
- R5: A frame is valid only if all of the following hold. No beat from its start to its end carried an effective parity error. A previous completed frame exists. When `cfgLenChkEn` = 1, its first line length equals the previous frame's. When `cfgLineChkEn` = 1, its line count equals the previous frame's. The first frame after reset is never valid.
- R6: `passOk` rises in the cycle after the frame-end beat that completes `cfgPassFrames` consecutive valid frames. A value of 0 in `cfgPassFrames` acts as 1.
- R7: An invalid frame clears `passOk` and restarts the run from zero. A frame start that arrives while a frame is still open also does this, and the unfinished frame is not used as a size reference.
- R8: When `cfgPassGateEn` = 1 and `passOk` = 0 at a frame start, every beat of that frame, up to and including its frame end, is dropped. Each such frame increments `dropFrmCnt`.
- R9: `sizeMisCnt` counts each completed frame that has a previous reference and fails an enabled size check.
- R10: When a forwarded frame start follows an earlier forwarded frame start with no forwarded frame end in between, `truncPulse` is high in the same cycle as that `outFs`.
- R11: The counters saturate at all ones. `statClear` sets them to zero and takes priority over a simultaneous increment.
- R12: With `cfgLenChkEn` = 1, a frame in which any line length differs from its first line's length is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Input beat valid |
| inData | input | DATA_W | Input beat data |
| inFs | input | 1 | Beat is a frame start |
| inFe | input | 1 | Beat is a frame end |
| inLs | input | 1 | Data beat opens a line |
| inLe | input | 1 | Data beat closes a line |
| inParErr | input | 1 | Parity error flag of the beat |
| cfgParChkEn | input | 1 | Honour the parity flag |
| cfgFwdParErr | input | 1 | Forward flagged beats instead of dropping them |
| cfgPassGateEn | input | 1 | Hold back frames until pass |
| cfgLenChkEn | input | 1 | Enable line length checking |
| cfgLineChkEn | input | 1 | Enable line count checking |
| cfgPassFrames | input | RUN_W | Valid frames needed for pass |
| statClear | input | 1 | Clear all counters |
| outValid | output | 1 | Output beat valid |
| outData | output | DATA_W | Output beat data |
| outFs | output | 1 | Output frame start |
| outFe | output | 1 | Output frame end |
| outLs | output | 1 | Output line start |
| outLe | output | 1 | Output line end |
| passOk | output | 1 | Pass status |
| truncPulse | output | 1 | Truncated frame seen downstream |
| parErrCnt | output | STAT_W | Parity error count |
| dropFrmCnt | output | STAT_W | Gated-off frame count |
| sizeMisCnt | output | STAT_W | Size mismatch count |

## Verification
The assertions check the following on every cycle:
- the one-cycle alignment of output data to input;
- that a flagged beat is gone when dropping is selected;
- that a frame start is blocked while gated without pass;
- that `passOk` only moves on a frame boundary;
- that the truncation pulse coincides with a forwarded start;
- that clearing empties the counters.

Some behaviour depends on history across whole frames, so only the directed scenarios can show it:
- the exact frame on which pass rises for a given run length;
- the way each size check and the parity controls decide validity;
- whole-frame suppression under gating;
- the recovery after an abandoned frame;
- counter saturation.

// File: rtl/vfg_pkg.sv
package vfg_pkg;

  // Per-beat strobes from control to datapath and counters
  typedef struct packed {
    logic keep;       // forward this beat
    logic dropFrame;  // a frame start was gated off
    logic parHit;     // effective parity error on this beat
    logic sizeMis;    // completed frame failed an enabled size check
  } vfg_strobe_t;

  typedef enum logic {
    PS_HUNT = 1'b0,
    PS_PASS = 1'b1
  } pass_state_t;

endpackage

// File: rtl/vfg_sat_counter.sv
module vfg_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && count != MAXV) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/vfg_ctrl.sv
module vfg_ctrl
  import vfg_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int LINE_W = 12,
  parameter int RUN_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inFs,
  input  logic             inFe,
  input  logic             inLs,
  input  logic             inLe,
  input  logic             inParErr,
  input  logic             cfgParChkEn,
  input  logic             cfgFwdParErr,
  input  logic             cfgPassGateEn,
  input  logic             cfgLenChkEn,
  input  logic             cfgLineChkEn,
  input  logic [RUN_W-1:0] cfgPassFrames,
  output vfg_strobe_t      strobe,
  output logic             passOk
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  // frame measurement state
  logic              inFrame;
  logic              parSeen;
  logic [LEN_W-1:0]  curLen;
  logic [LEN_W-1:0]  firstLen;
  logic              firstLenDone;
  logic              intraMis;
  logic [LINE_W-1:0] lineCnt;
  logic [LEN_W-1:0]  refLen;
  logic [LINE_W-1:0] refLines;
  logic              refValid;
  logic              gateOpen;

  // pass machine state
  pass_state_t       state;
  logic [RUN_W-1:0]  runCnt;

  logic              effPar, isFs, isFe, isData;
  logic [LEN_W-1:0]  lineLenNow;
  logic              gateNow, frameGate;
  logic              lenBad, lineBad, frameOk;
  logic              evalEnd, abandon;
  logic [RUN_W-1:0]  passTarget, runInc;

  always_comb begin
    effPar     = inValid & inParErr & cfgParChkEn;
    isFs       = inValid & inFs;
    isFe       = inValid & inFe;
    isData     = inValid & ~inFs & ~inFe;
    lineLenNow = inLs ? LEN_W'(1) : curLen + 1'b1;
    gateNow    = ~(cfgPassGateEn & (state != PS_PASS));
    frameGate  = (inFrame & ~isFs) ? gateOpen : gateNow;
    lenBad     = cfgLenChkEn & ((firstLen != refLen) | intraMis);
    lineBad    = cfgLineChkEn & (lineCnt != refLines);
    frameOk    = ~(parSeen | effPar) & refValid & ~lenBad & ~lineBad;
    evalEnd    = isFe & inFrame;
    abandon    = isFs & inFrame;
    passTarget = (cfgPassFrames == '0) ? RUN_ONE : cfgPassFrames;
    runInc     = (runCnt == RUN_MAX) ? runCnt : runCnt + 1'b1;

    strobe.keep      = inValid & frameGate & ~(effPar & ~cfgFwdParErr);
    strobe.dropFrame = isFs & ~gateNow;
    strobe.parHit    = effPar;
    strobe.sizeMis   = evalEnd & refValid & (lenBad | lineBad);
  end

  // frame geometry tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      parSeen      <= 1'b0;
      curLen       <= '0;
      firstLen     <= '0;
      firstLenDone <= 1'b0;
      intraMis     <= 1'b0;
      lineCnt      <= '0;
      refLen       <= '0;
      refLines     <= '0;
      refValid     <= 1'b0;
      gateOpen     <= 1'b0;
    end else begin
      if (isData) begin
        curLen <= lineLenNow;
        if (inLe) begin
          lineCnt <= lineCnt + 1'b1;
          if (!firstLenDone) begin
            firstLen     <= lineLenNow;
            firstLenDone <= 1'b1;
          end else if (lineLenNow != firstLen) begin
            intraMis <= 1'b1;
          end
        end
      end
      if (inFrame && effPar) parSeen <= 1'b1;
      if (isFs) begin
        inFrame      <= 1'b1;
        parSeen      <= effPar;
        curLen       <= '0;
        firstLen     <= '0;
        firstLenDone <= 1'b0;
        intraMis     <= 1'b0;
        lineCnt      <= '0;
        gateOpen     <= gateNow;
      end
      if (evalEnd) begin
        inFrame  <= 1'b0;
        refLen   <= firstLen;
        refLines <= lineCnt;
        refValid <= 1'b1;
      end
    end
  end

  // pass state machine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= PS_HUNT;
      runCnt <= '0;
    end else if (abandon) begin
      state  <= PS_HUNT;
      runCnt <= '0;
    end else if (evalEnd) begin
      if (frameOk) begin
        runCnt <= runInc;
        if (runInc >= passTarget) state <= PS_PASS;
      end else begin
        runCnt <= '0;
        state  <= PS_HUNT;
      end
    end
  end

  assign passOk = (state == PS_PASS);
endmodule

// File: rtl/vfg_datapath.sv
module vfg_datapath
  import vfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  vfg_strobe_t       strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFs,
  input  logic              inFe,
  input  logic              inLs,
  input  logic              inLe,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outFs,
  output logic              outFe,
  output logic              outLs,
  output logic              outLe,
  output logic              truncPulse
);
  logic outOpen;  // a forwarded frame start still awaits its end
  logic keep;

  assign keep = strobe.keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outData    <= '0;
      outFs      <= 1'b0;
      outFe      <= 1'b0;
      outLs      <= 1'b0;
      outLe      <= 1'b0;
      truncPulse <= 1'b0;
      outOpen    <= 1'b0;
    end else begin
      outValid   <= keep;
      outData    <= keep ? inData : '0;
      outFs      <= keep & inFs;
      outFe      <= keep & inFe;
      outLs      <= keep & inLs;
      outLe      <= keep & inLe;
      truncPulse <= keep & inFs & outOpen;
      if (keep && inFs)      outOpen <= 1'b1;
      else if (keep && inFe) outOpen <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_frame_gate.sv
module vid_frame_gate
  import vfg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int LINE_W = 12,
  parameter int RUN_W  = 4,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFs,
  input  logic              inFe,
  input  logic              inLs,
  input  logic              inLe,
  input  logic              inParErr,
  input  logic              cfgParChkEn,
  input  logic              cfgFwdParErr,
  input  logic              cfgPassGateEn,
  input  logic              cfgLenChkEn,
  input  logic              cfgLineChkEn,
  input  logic [RUN_W-1:0]  cfgPassFrames,
  input  logic              statClear,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outFs,
  output logic              outFe,
  output logic              outLs,
  output logic              outLe,
  output logic              passOk,
  output logic              truncPulse,
  output logic [STAT_W-1:0] parErrCnt,
  output logic [STAT_W-1:0] dropFrmCnt,
  output logic [STAT_W-1:0] sizeMisCnt
);
  localparam int NUM_STATS = 3;

  vfg_strobe_t              strobe;
  logic [NUM_STATS-1:0]     statInc;
  logic [STAT_W-1:0]        statVal [NUM_STATS];

  vfg_ctrl #(
    .LEN_W (LEN_W),
    .LINE_W(LINE_W),
    .RUN_W (RUN_W)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inFs         (inFs),
    .inFe         (inFe),
    .inLs         (inLs),
    .inLe         (inLe),
    .inParErr     (inParErr),
    .cfgParChkEn  (cfgParChkEn),
    .cfgFwdParErr (cfgFwdParErr),
    .cfgPassGateEn(cfgPassGateEn),
    .cfgLenChkEn  (cfgLenChkEn),
    .cfgLineChkEn (cfgLineChkEn),
    .cfgPassFrames(cfgPassFrames),
    .strobe       (strobe),
    .passOk       (passOk)
  );

  vfg_datapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .inFs      (inFs),
    .inFe      (inFe),
    .inLs      (inLs),
    .inLe      (inLe),
    .outValid  (outValid),
    .outData   (outData),
    .outFs     (outFs),
    .outFe     (outFe),
    .outLs     (outLs),
    .outLe     (outLe),
    .truncPulse(truncPulse)
  );

  assign statInc = {strobe.sizeMis, strobe.dropFrame, strobe.parHit};

  for (genvar gi = 0; gi < NUM_STATS; gi++) begin : gStat
    vfg_sat_counter #(
      .W(STAT_W)
    ) uCnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (statClear),
      .inc  (statInc[gi]),
      .count(statVal[gi])
    );
  end

  assign parErrCnt  = statVal[0];
  assign dropFrmCnt = statVal[1];
  assign sizeMisCnt = statVal[2];
endmodule

// File: rtl/vfg_checker.sv
module vfg_checker #(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inFs,
  input logic              inFe,
  input logic              inParErr,
  input logic              cfgParChkEn,
  input logic              cfgFwdParErr,
  input logic              cfgPassGateEn,
  input logic              statClear,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outFs,
  input logic              passOk,
  input logic              truncPulse,
  input logic [STAT_W-1:0] parErrCnt,
  input logic [STAT_W-1:0] dropFrmCnt,
  input logic [STAT_W-1:0] sizeMisCnt
);
  assert_out_from_in_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(inValid) && outData == $past(inData)));

  assert_par_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inParErr && cfgParChkEn && !cfgFwdParErr) |=> !outValid);

  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFs && cfgPassGateEn && !passOk) |=> !outValid);

  assert_pass_rise_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passOk) |-> $past(inValid && inFe));

  assert_pass_fall_at_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(passOk) |-> $past(inValid && (inFe || inFs)));

  assert_trunc_on_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    truncPulse |-> (outValid && outFs));

  assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    statClear |=> (parErrCnt == '0 && dropFrmCnt == '0 && sizeMisCnt == '0));
endmodule

bind vid_frame_gate vfg_checker #(
  .DATA_W(DATA_W),
  .STAT_W(STAT_W)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inData       (inData),
  .inFs         (inFs),
  .inFe         (inFe),
  .inParErr     (inParErr),
  .cfgParChkEn  (cfgParChkEn),
  .cfgFwdParErr (cfgFwdParErr),
  .cfgPassGateEn(cfgPassGateEn),
  .statClear    (statClear),
  .outValid     (outValid),
  .outData      (outData),
  .outFs        (outFs),
  .passOk       (passOk),
  .truncPulse   (truncPulse),
  .parErrCnt    (parErrCnt),
  .dropFrmCnt   (dropFrmCnt),
  .sizeMisCnt   (sizeMisCnt)
);

// File: tb/sim_vid_frame_gate.sv
`timescale 1ns/1ps
module sim_vid_frame_gate;
  localparam int DW = 16;
  localparam int RW = 4;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 0, inFs = 0, inFe = 0, inLs = 0, inLe = 0, inParErr = 0;
  logic [DW-1:0] inData = '0;
  logic cfgParChkEn = 1, cfgFwdParErr = 0, cfgPassGateEn = 0;
  logic cfgLenChkEn = 1, cfgLineChkEn = 1;
  logic [RW-1:0] cfgPassFrames = 4'd3;
  logic statClear = 0;
  logic outValid, outFs, outFe, outLs, outLe, passOk, truncPulse;
  logic [DW-1:0] outData;
  logic [SW-1:0] parErrCnt, dropFrmCnt, sizeMisCnt;

  int total = 0, bad = 0;
  int nOut = 0, nFs = 0, nFe = 0, nTrunc = 0, dataSum = 0, expSum = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vid_frame_gate #(.DATA_W(DW), .RUN_W(RW), .STAT_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inFs(inFs), .inFe(inFe), .inLs(inLs), .inLe(inLe), .inParErr(inParErr),
    .cfgParChkEn(cfgParChkEn), .cfgFwdParErr(cfgFwdParErr),
    .cfgPassGateEn(cfgPassGateEn), .cfgLenChkEn(cfgLenChkEn),
    .cfgLineChkEn(cfgLineChkEn), .cfgPassFrames(cfgPassFrames),
    .statClear(statClear), .outValid(outValid), .outData(outData),
    .outFs(outFs), .outFe(outFe), .outLs(outLs), .outLe(outLe),
    .passOk(passOk), .truncPulse(truncPulse), .parErrCnt(parErrCnt),
    .dropFrmCnt(dropFrmCnt), .sizeMisCnt(sizeMisCnt));

  // output monitor, sampled after each rising edge settles
  always @(posedge clk) begin
    #1;
    if (outValid) begin
      nOut++;
      dataSum += int'(outData);
      if (outFs) nFs++;
      if (outFe) nFe++;
    end
    if (truncPulse) nTrunc++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk);
    nOut = 0; nFs = 0; nFe = 0; nTrunc = 0; dataSum = 0; expSum = 0;
  endtask

  task automatic beat(input bit fs, input bit fe, input bit ls, input bit le,
                      input bit par, input int data);
    @(negedge clk);
    inValid = 1; inFs = fs; inFe = fe; inLs = ls; inLe = le;
    inParErr = par; inData = DW'(data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 0; inFs = 0; inFe = 0; inLs = 0; inLe = 0; inParErr = 0;
    end
  endtask

  // beat index 0 is the frame start, data beats follow, frame end last
  task automatic sendFrame(input int lines, input int len, input int lastLen,
                           input int parAt, input bit withFe);
    int idx = 0;
    int ll;
    bit p;
    p = (parAt == idx);
    beat(1, 0, 0, 0, p, 100 + idx);
    if (!(p && cfgParChkEn && !cfgFwdParErr)) expSum += 100 + idx;
    for (int l = 0; l < lines; l++) begin
      ll = (l == lines - 1) ? lastLen : len;
      for (int b = 0; b < ll; b++) begin
        idx++;
        p = (parAt == idx);
        beat(0, 0, b == 0, b == ll - 1, p, 100 + idx);
        if (!(p && cfgParChkEn && !cfgFwdParErr)) expSum += 100 + idx;
      end
    end
    if (withFe) begin
      idx++;
      p = (parAt == idx);
      beat(0, 1, 0, 0, p, 100 + idx);
      if (!(p && cfgParChkEn && !cfgFwdParErr)) expSum += 100 + idx;
    end
    idle(3);
  endtask

  task automatic doReset(input int passN);
    @(negedge clk);
    rstN = 0;
    cfgParChkEn = 1; cfgFwdParErr = 0; cfgPassGateEn = 0;
    cfgLenChkEn = 1; cfgLineChkEn = 1; cfgPassFrames = RW'(passN);
    idle(3);
    rstN = 1;
    idle(1);
  endtask

  task automatic t_reset();
    doReset(3);
    chk("R1 reset outValid", outValid, 0);
    chk("R6 reset passOk", passOk, 0);
    chk("R11 reset parErrCnt", parErrCnt, 0);
    chk("R11 reset dropFrmCnt", dropFrmCnt, 0);
  endtask

  task automatic t_basic();
    doReset(3);
    clearMon();
    sendFrame(2, 3, 3, -1, 1);
    chk("R1 beats forwarded", nOut, 8);
    chk("R1 data sum", dataSum, expSum);
    chk("R1 frame markers", nFs + nFe, 2);
    chk("R5 first frame not valid", passOk, 0);
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    chk("R6 pass not yet after two valid", passOk, 0);
    sendFrame(2, 3, 3, -1, 1);
    chk("R6 pass after three valid", passOk, 1);
  endtask

  task automatic t_passZero();
    doReset(0);
    sendFrame(2, 3, 3, -1, 1);
    chk("R6 zero target first frame", passOk, 0);
    sendFrame(2, 3, 3, -1, 1);
    chk("R6 zero target acts as one", passOk, 1);
  endtask

  task automatic t_parity();
    doReset(1);
    cfgParChkEn = 0;
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    clearMon();
    sendFrame(2, 3, 3, 2, 1);
    chk("R2 flag ignored beats", nOut, 8);
    chk("R2 flag ignored pass", passOk, 1);
    chk("R2 flag ignored count", parErrCnt, 0);
    cfgParChkEn = 1; cfgFwdParErr = 1;
    clearMon();
    sendFrame(2, 3, 3, 2, 1);
    chk("R3 forward flagged beat", nOut, 8);
    chk("R3 forwarded data sum", dataSum, expSum);
    chk("R4 parity counted", parErrCnt, 1);
    chk("R7 parity frame clears pass", passOk, 0);
    sendFrame(2, 3, 3, -1, 1);
    cfgFwdParErr = 0;
    clearMon();
    sendFrame(2, 3, 3, 2, 1);
    chk("R3 drop flagged beat", nOut, 7);
    chk("R3 dropped data sum", dataSum, expSum);
    chk("R4 dropped beat counted", parErrCnt, 2);
  endtask

  task automatic t_size();
    doReset(1);
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    chk("R5 equal size valid", passOk, 1);
    sendFrame(3, 3, 3, -1, 1);
    chk("R5 line count mismatch", passOk, 0);
    chk("R9 mismatch counted", sizeMisCnt, 1);
    cfgLenChkEn = 0;
    sendFrame(3, 5, 5, -1, 1);
    chk("R5 length check off", passOk, 1);
    chk("R9 no count when disabled", sizeMisCnt, 1);
    cfgLenChkEn = 1;
    sendFrame(3, 5, 4, -1, 1);
    chk("R12 uneven lines invalid", passOk, 0);
    chk("R12 uneven lines counted", sizeMisCnt, 2);
  endtask

  task automatic t_abandon();
    doReset(2);
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    chk("R6 pass before abandon", passOk, 1);
    sendFrame(2, 3, 3, -1, 0);
    sendFrame(2, 3, 3, -1, 1);
    chk("R7 abandoned frame restarts run", passOk, 0);
  endtask

  task automatic t_gate();
    doReset(2);
    cfgPassGateEn = 1;
    clearMon();
    sendFrame(2, 3, 3, -1, 1);
    chk("R8 gated frame no beats", nOut, 0);
    chk("R8 gated frame no end", nFe, 0);
    sendFrame(2, 3, 3, -1, 1);
    sendFrame(2, 3, 3, -1, 1);
    chk("R8 dropped frames counted", dropFrmCnt, 3);
    chk("R8 pass earned while gated", passOk, 1);
    clearMon();
    sendFrame(2, 3, 3, -1, 1);
    chk("R8 frame passes after pass", nOut, 8);
  endtask

  task automatic t_trunc();
    doReset(3);
    clearMon();
    sendFrame(2, 3, 3, 7, 1);
    chk("R3 end beat dropped", nFe, 0);
    chk("R10 no pulse yet", nTrunc, 0);
    sendFrame(2, 3, 3, -1, 1);
    chk("R10 truncation flagged", nTrunc, 1);
    sendFrame(2, 3, 3, -1, 1);
    chk("R10 complete frame no pulse", nTrunc, 1);
  endtask

  task automatic t_counters();
    doReset(3);
    for (int i = 0; i < 20; i++) beat(0, 0, 0, 0, 1, i);
    idle(2);
    chk("R11 saturate", parErrCnt, 15);
    @(negedge clk);
    inValid = 1; inParErr = 1; statClear = 1;
    @(negedge clk);
    inValid = 0; inParErr = 0; statClear = 0;
    idle(1);
    chk("R11 clear wins", parErrCnt, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_passZero();
    t_parity();
    t_size();
    t_abandon();
    t_gate();
    t_trunc();
    t_counters();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule